// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-facing register file of a simple serial port. A 32-bit register bus reaches five word registers: a receive buffer, a transmit holding register, a control word, a status word and a baud divisor. The serial shifters, the two FIFOs and the baud tick generator sit outside. The block drives their control strobes, passes bytes to and from them, and turns their conditions into two interrupt lines.

Bytes leave toward the transmit FIFO on a valid/ready stream. `tx_valid` is raised only in the cycle of a transmit-holding write that finds `tx_ready` high, so every valid cycle is a transfer. A write that meets a full FIFO is dropped and never retried. Bytes arrive from the receive FIFO on a second stream. `rx_valid` means the FIFO holds a byte. `rx_ready` pulses for exactly one cycle when the bus reads the receive buffer while `rx_valid` is high, and that pulse pops the entry.

Receive error events arrive as single-cycle pulses. Each one is latched into a status bit that stays set until software writes a one to that bit. The baud divisor field feeds the tick generator, which runs at sixteen times the bit rate. Software loads it with ceil(f_clk / (16 × baud)).

Top module: `uart_csr`

## Requirements
- R1: After reset, the control and baud registers read 0. Both interrupts and all four control strobes (`soft_rst`, `txf_rst`, `rxf_rst`, `send_break`) are low, and the four latched error bits read 0.
- R2: Control register (address 0x08) field positions:
  - bit 31 drives `soft_rst`;
  - bit 15 drives `txf_rst`;
  - bit 14 drives `rxf_rst`;
  - bit 11 drives `send_break`;
  - bit 5 enables the TX interrupt and bit 4 the RX-ready interrupt;
  - bits 3..0 enable the error interrupts for break, framing, parity and overrun, in that order.

  Only these bits are stored (read-back mask 0x8000C83F). Other bits read 0. Each strobe follows its stored bit from the cycle after the write, for as long as the bit is set.
- R3: The baud register (0x10) stores all 32 written bits and reads them back. `baud_div` equals bits 9..0 only. The upper bits have no effect on it.
- R4: A write to the transmit holding register (0x04) while `tx_ready` is high raises `tx_valid` in that same cycle, with `tx_data` equal to write-data bits 7..0. With `tx_ready` low, or at any other address, `tx_valid` stays low.
- R5: A read of the receive buffer (0x00) while `rx_valid` is high returns `rx_data` in bits 7..0 with the upper bits zero, and raises `rx_ready` in that cycle. While `rx_valid` is low the read returns 0 and `rx_ready` stays low.
- R6: Status register (0x0C) bit positions:
  - bit 13 = `tx_fifo_empty`;
  - bit 11 = FIFO full, that is NOT `tx_ready`;
  - bit 6 = `tx_idle`;
  - bit 5 = `tx_ready`;
  - bit 4 = `rx_valid`;
  - bits 3..0 = latched break, framing, parity and overrun errors.

  Every other bit reads 0.
- R7: A one on `err_event[i]` (3 = break, 2 = framing, 1 = parity, 0 = overrun) sets latched error bit i at the next clock edge. The bit then holds.
- R8: A status write clears each latched error bit whose write-data bit is one. Bits written with zero are unchanged. An event in the same cycle as its clear leaves the bit set.
- R9: `irq_rx` = (`rx_valid` AND control bit 4) OR (any latched error bit i AND control bit i). It follows its inputs in the same cycle.
- R10: `irq_tx` = `tx_ready` AND control bit 5, in the same cycle.
- R11: Reads of unmapped addresses return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| tx_valid | output | 1 | Byte offered to the transmit FIFO |
| tx_data | output | 8 | Byte for the transmit FIFO |
| tx_ready | input | 1 | Transmit FIFO has room |
| rx_valid | input | 1 | Receive FIFO holds a byte |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_ready | output | 1 | Pop strobe to the receive FIFO |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_idle | input | 1 | Transmitter has shifted out everything |
| err_event | input | ERR_N | Receive error pulses: break, framing, parity, overrun |
| soft_rst | output | 1 | Datapath soft reset level |
| txf_rst | output | 1 | Transmit FIFO reset level |
| rxf_rst | output | 1 | Receive FIFO reset level |
| send_break | output | 1 | Hold the line in break |
| baud_div | output | DIV_W | Divisor for the 16x oversampling tick |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench builds the block with its defaults: a 5-bit address, a 32-bit data word, a 10-bit divisor and four error sources. At that size every divisor value (1024 of them) can be loaded with a varying pattern in the upper bits. All 1024 combinations of the ten stored control bits can be written, and all 256 receive byte values can be read back. Each of the 16 latched-error masks is crossed with all 64 interrupt-enable settings and all four `rx_valid`/`tx_ready` states, so both interrupt equations are checked over their whole input space. Every write-one-to-clear mask is also applied, including a clear that lands in the same cycle as its set event.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  // Register byte offsets
  localparam int unsigned OFF_RXB  = 0;
  localparam int unsigned OFF_TXH  = 4;
  localparam int unsigned OFF_CTL  = 8;
  localparam int unsigned OFF_STS  = 12;
  localparam int unsigned OFF_BAUD = 16;

  // Control word bit positions
  localparam int unsigned CB_SRST = 31;
  localparam int unsigned CB_TXFR = 15;
  localparam int unsigned CB_RXFR = 14;
  localparam int unsigned CB_BRK  = 11;
  localparam int unsigned CB_TXIE = 5;
  localparam int unsigned CB_RXIE = 4;

  // Status word bit positions
  localparam int unsigned SB_TXEMP  = 13;
  localparam int unsigned SB_TXFULL = 11;
  localparam int unsigned SB_IDLE   = 6;
  localparam int unsigned SB_TXRDY  = 5;
  localparam int unsigned SB_RXRDY  = 4;

  localparam logic [31:0] CTL_MASK = (32'h1 << CB_SRST) | (32'h1 << CB_TXFR) |
                                     (32'h1 << CB_RXFR) | (32'h1 << CB_BRK)  |
                                     (32'h1 << CB_TXIE) | (32'h1 << CB_RXIE) |
                                     32'h0000_000F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RXB,
    SEL_TXH,
    SEL_CTL,
    SEL_STS,
    SEL_BAUD
  } reg_sel_e;

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if      (addr == ADDR_W'(OFF_RXB))  sel = SEL_RXB;
    else if (addr == ADDR_W'(OFF_TXH))  sel = SEL_TXH;
    else if (addr == ADDR_W'(OFF_CTL))  sel = SEL_CTL;
    else if (addr == ADDR_W'(OFF_STS))  sel = SEL_STS;
    else if (addr == ADDR_W'(OFF_BAUD)) sel = SEL_BAUD;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/uart_csr_errlatch.sv
module uart_csr_errlatch #(
  parameter int unsigned ERR_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] ev,
  input  logic [ERR_N-1:0] clr,
  output logic [ERR_N-1:0] q
);

  for (genvar i = 0; i < ERR_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= 1'b0;
      else if (ev[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> q[i]);

    // R8
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !ev[i]) |=> !q[i]);
  end

endmodule

// File: rtl/uart_csr_irq.sv
module uart_csr_irq #(
  parameter int unsigned ERR_N = 4
) (
  input  logic [ERR_N-1:0] err_q,
  input  logic [ERR_N-1:0] err_en,
  input  logic             rx_avail,
  input  logic             rx_en,
  input  logic             tx_room,
  input  logic             tx_en,
  output logic             irq_rx,
  output logic             irq_tx
);

  always_comb begin
    irq_rx = (rx_avail & rx_en) | (|(err_q & err_en));
    irq_tx = tx_room & tx_en;
  end

endmodule

// File: rtl/uart_csr.sv
module uart_csr
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned ERR_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              tx_fifo_empty,
  input  logic              tx_idle,
  input  logic [ERR_N-1:0]  err_event,
  output logic              soft_rst,
  output logic              txf_rst,
  output logic              rxf_rst,
  output logic              send_break,
  output logic [DIV_W-1:0]  baud_div,
  output logic              irq_rx,
  output logic              irq_tx
);

  localparam logic [DATA_W-1:0] CTL_KEEP = DATA_W'(CTL_MASK);

  reg_sel_e          sel;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] baud_q;
  logic [ERR_N-1:0]  err_q;
  logic [ERR_N-1:0]  err_clr;
  logic [DATA_W-1:0] sts_word;

  uart_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_CTL)  ctl_q  <= bus_wdata & CTL_KEEP;
      if (sel == SEL_BAUD) baud_q <= bus_wdata;
    end
  end

  assign err_clr = (bus_wr && sel == SEL_STS) ? bus_wdata[ERR_N-1:0] : '0;

  uart_csr_errlatch #(.ERR_N(ERR_N)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (err_event),
    .clr   (err_clr),
    .q     (err_q)
  );

  uart_csr_irq #(.ERR_N(ERR_N)) u_irq (
    .err_q    (err_q),
    .err_en   (ctl_q[ERR_N-1:0]),
    .rx_avail (rx_valid),
    .rx_en    (ctl_q[CB_RXIE]),
    .tx_room  (tx_ready),
    .tx_en    (ctl_q[CB_TXIE]),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx)
  );

  always_comb begin
    sts_word              = '0;
    sts_word[SB_TXEMP]    = tx_fifo_empty;
    sts_word[SB_TXFULL]   = ~tx_ready;
    sts_word[SB_IDLE]     = tx_idle;
    sts_word[SB_TXRDY]    = tx_ready;
    sts_word[SB_RXRDY]    = rx_valid;
    sts_word[ERR_N-1:0]   = err_q;
  end

  always_comb begin
    unique case (sel)
      SEL_RXB:  bus_rdata = rx_valid ? DATA_W'(rx_data) : '0;
      SEL_CTL:  bus_rdata = ctl_q;
      SEL_STS:  bus_rdata = sts_word;
      SEL_BAUD: bus_rdata = baud_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign tx_valid   = bus_wr && sel == SEL_TXH && tx_ready;
  assign tx_data    = bus_wdata[7:0];
  assign rx_ready   = bus_rd && sel == SEL_RXB && rx_valid;
  assign soft_rst   = ctl_q[CB_SRST];
  assign txf_rst    = ctl_q[CB_TXFR];
  assign rxf_rst    = ctl_q[CB_RXFR];
  assign send_break = ctl_q[CB_BRK];
  assign baud_div   = baud_q[DIV_W-1:0];

  // R2
  ctl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_CTL)) |=>
      (soft_rst == $past(bus_wdata[CB_SRST]) && send_break == $past(bus_wdata[CB_BRK]) &&
       txf_rst == $past(bus_wdata[CB_TXFR]) && rxf_rst == $past(bus_wdata[CB_RXFR])));

  // R3
  baud_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_BAUD)) |=> (baud_div == $past(bus_wdata[DIV_W-1:0])));

  // R5
  rx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_rdata == DATA_W'(rx_data)));

endmodule

// File: tb/uart_csr_bench.sv
module uart_csr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_fifo_empty = 1'b0;
  logic        tx_idle = 1'b0;
  logic [3:0]  err_event = '0;
  logic        soft_rst, txf_rst, rxf_rst, send_break;
  logic [9:0]  baud_div;
  logic        irq_rx, irq_tx;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_csr u_uart_csr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_fifo_empty(tx_fifo_empty), .tx_idle(tx_idle), .err_event(err_event),
    .soft_rst(soft_rst), .txf_rst(txf_rst), .rxf_rst(rxf_rst), .send_break(send_break),
    .baud_div(baud_div), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic pop);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; pop = rx_ready;
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    err_event = e;
    @(negedge clk);
    err_event = '0;
    #1;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    check("R1 strobes", {28'd0, soft_rst, txf_rst, rxf_rst, send_break}, 32'd0);
    check("R1 irqs", {30'd0, irq_rx, irq_tx}, 32'd0);
    rd(5'h08, d, p); check("R1 ctl", d, 32'd0);
    rd(5'h10, d, p); check("R1 baud", d, 32'd0);
    rd(5'h0C, d, p); check("R1 errs", {28'd0, d[3:0]}, 32'd0);

    // R2 sweep over the ten stored control bits
    for (int idx = 0; idx < 1024; idx++) begin
      logic [9:0]  b;
      logic [31:0] w;
      logic [31:0] g;
      b = idx[9:0];
      w = {b[9], 15'd0, b[8], b[7], 2'd0, b[6], 5'd0, b[5], b[4], b[3], b[2], b[1], b[0]};
      g = {b, b, b, 2'b10} & ~32'h8000C83F;
      wr(5'h08, w | g);
      check("R2 strobes", {28'd0, soft_rst, txf_rst, rxf_rst, send_break},
            {28'd0, b[9], b[8], b[7], b[6]});
      if (idx % 64 == 0 || idx == 1023) begin
        rd(5'h08, d, p); check("R2 readback", d, w);
      end
    end
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d, p); check("R2 all ones", d, 32'h8000C83F);
    wr(5'h08, 32'd0);

    // R3 divisor sweep with varying upper bits
    for (int dv = 0; dv < 1024; dv++) begin
      logic [31:0] w;
      w = {dv[9:0] ^ 10'h2A5, dv[11:0] * 12'd37} << 10 | 32'(dv);
      wr(5'h10, w);
      check("R3 divisor", {22'd0, baud_div}, 32'(dv));
      if (dv % 128 == 5) begin
        rd(5'h10, d, p); check("R3 readback", d, w);
      end
    end

    // R4 transmit push
    tx_ready = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      bus_addr = 5'h04; bus_wdata = 32'hABCD_0000 | 32'(k * 17); bus_wr = 1'b1;
      #1;
      check("R4 push valid", {31'd0, tx_valid}, 32'd1);
      check("R4 push data", {24'd0, tx_data}, 32'(k * 17));
      @(negedge clk); bus_wr = 1'b0;
    end
    tx_ready = 1'b0;
    @(negedge clk);
    bus_addr = 5'h04; bus_wdata = 32'h55; bus_wr = 1'b1;
    #1; check("R4 full drop", {31'd0, tx_valid}, 32'd0);
    @(negedge clk); bus_wr = 1'b0;
    tx_ready = 1'b1;
    @(negedge clk);
    bus_addr = 5'h08; bus_wdata = 32'h0; bus_wr = 1'b1;
    #1; check("R4 other addr", {31'd0, tx_valid}, 32'd0);
    @(negedge clk); bus_wr = 1'b0;
    tx_ready = 1'b0;

    // R5 receive reads
    rx_valid = 1'b1;
    for (int v = 0; v < 256; v++) begin
      rx_data = v[7:0];
      rd(5'h00, d, p);
      check("R5 data", d, 32'(v));
      check("R5 pop", {31'd0, p}, 32'd1);
    end
    rx_valid = 1'b0; rx_data = 8'hC3;
    rd(5'h00, d, p);
    check("R5 empty data", d, 32'd0);
    check("R5 empty pop", {31'd0, p}, 32'd0);

    // R6 status bit positions
    wr(5'h0C, 32'hF);
    for (int s = 0; s < 16; s++) begin
      tx_ready = s[0]; tx_fifo_empty = s[1]; tx_idle = s[2]; rx_valid = s[3];
      rd(5'h0C, d, p);
      check("R6 status", d, (32'(s[1]) << 13) | (32'(!s[0]) << 11) | (32'(s[2]) << 6) |
                            (32'(s[0]) << 5) | (32'(s[3]) << 4));
    end
    tx_ready = 1'b0; tx_fifo_empty = 1'b0; tx_idle = 1'b0; rx_valid = 1'b0;

    // R7 latch and R8 write-one-to-clear
    for (int w = 0; w < 16; w++) begin
      wr(5'h0C, 32'hF);
      pulse(4'(w));
      rd(5'h0C, d, p); check("R7 latch", {28'd0, d[3:0]}, 32'(w));
      pulse(4'hF);
      wr(5'h0C, 32'(w) | 32'hFFF0);
      rd(5'h0C, d, p); check("R8 clear", {28'd0, d[3:0]}, 32'(4'hF & ~4'(w)));
    end
    wr(5'h0C, 32'hF);
    @(negedge clk);
    bus_addr = 5'h0C; bus_wdata = 32'hF; bus_wr = 1'b1; err_event = 4'b0101;
    @(negedge clk);
    bus_wr = 1'b0; err_event = '0;
    rd(5'h0C, d, p); check("R8 set wins", {28'd0, d[3:0]}, 32'h5);

    // R9 and R10 interrupt sweep
    for (int e = 0; e < 16; e++) begin
      wr(5'h0C, 32'hF);
      pulse(4'(e));
      for (int en = 0; en < 64; en++) begin
        wr(5'h08, 32'(en));
        for (int m = 0; m < 4; m++) begin
          @(negedge clk);
          rx_valid = m[0]; tx_ready = m[1];
          #1;
          check("R9 irq_rx", {31'd0, irq_rx},
                {31'd0, (m[0] & en[4]) | (|(4'(e) & 4'(en)))});
          check("R10 irq_tx", {31'd0, irq_tx}, {31'd0, m[1] & en[5]});
        end
      end
    end
    rx_valid = 1'b0; tx_ready = 1'b0;

    // R11 unmapped addresses
    wr(5'h08, 32'h0000_0021);
    wr(5'h10, 32'h0000_0123);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF);
    rd(5'h14, d, p); check("R11 read 0x14", d, 32'd0);
    rd(5'h02, d, p); check("R11 read 0x02", d, 32'd0);
    rd(5'h08, d, p); check("R11 ctl kept", d, 32'h21);
    rd(5'h10, d, p); check("R11 baud kept", d, 32'h123);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule